// File: doc/BRIEF.md
# Write-Enable Latch and Status Controller

This block keeps the volatile status byte of a clock/calendar register file and decides, for every data byte a serial bus engine delivers, whether that byte may be written and whether it should be acknowledged. It sits between the bus engine and both the register space and the memory array. The engine gives it the start address of a transfer, the data strobes and a pulse when the transfer ends. The block returns the gating decision for each byte, the pointer for the next byte and a commit pulse when staged updates may be applied.

Writes are locked after reset and after power-up. Software opens them in two steps. It writes one status code that arms the general write latch, then a second code that also arms the register write latch. Accesses move through the register space section by section. The pointer wraps inside the section where the transfer began. The single-byte sections stay in place, and the status byte accepts only one data byte per transfer. A clock-fail flag is raised on power-up and stays set until the first committed write to the clock section. A battery flag copies the supply-mode input.

Top module: `wel_status_ctrl`

## Requirements
- R1: After reset, status_o is 01h, next_addr is 00h, and wr_allow, ack_suppress and commit_o are 0.
- R2: status_o bit 7 shows bat_mode as it was one clock earlier. Bits 6 to 3 read 0. Bit 2 is the register write latch, bit 1 is the general write latch and bit 0 is the clock-fail flag.
- R3: A first data byte written to address 3Fh is always accepted (wr_allow=1, ack_suppress=0). The value 02h sets bit 1 and clears bit 2, and the change shows in status_o on the next cycle.
- R4: Writing 06h to 3Fh sets both bits 2 and 1 when bit 1 is already set. When bit 1 is clear, it changes nothing.
- R5: Writing 00h to 3Fh clears bits 2 and 1. Any value other than 00h, 02h or 06h leaves both unchanged.
- R6: In a transfer that starts at 3Fh, every data byte after the first has ack_suppress=1 and wr_allow=0 and has no effect on status_o.
- R7: For the mapped register sections (00h-07h, 08h-0Fh, 10h, 30h-37h): with bit 1 clear, a byte gets ack_suppress=1 and wr_allow=0. With bit 1 set and bit 2 clear, it gets ack_suppress=0 and wr_allow=0. With both set, it gets wr_allow=1.
- R8: A register-space write to an unmapped address (11h-2Fh, 38h-3Eh) gets ack_suppress=1 and wr_allow=0.
- R9: In a transfer started with acc_arr=1 (array access), wr_allow equals bit 1, ack_suppress is its inverse, and the pointer steps by one modulo 64.
- R10: After each data byte, next_addr moves to the following address. Inside 00h-07h, 08h-0Fh and 30h-37h, only the low three bits count, modulo 8. At 10h and 3Fh the pointer stays put. Elsewhere it steps by one modulo 64.
- R11: acc_start loads acc_addr into next_addr on the following cycle. Read bytes advance the pointer by the same rule as write bytes.
- R12: commit_o is high for one cycle after stop_pulse only if the transfer had at least one allowed non-status write and, at the stop, bit 1 is set and bit 2 is also set (bit 2 is not needed for array transfers).
- R13: A commit for a transfer that wrote the clock section (30h-37h) clears bit 0, in the same cycle commit_o rises. A pwr_up pulse sets bit 0 and clears bits 2 and 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_start | input | 1 | Transfer start, loads the pointer |
| acc_addr | input | 6 | Start address of the transfer |
| acc_arr | input | 1 | Transfer targets the memory array (1) or register space (0) |
| wr_stb | input | 1 | A data byte is being written at the current pointer |
| wr_data | input | 8 | Data byte for wr_stb |
| rd_stb | input | 1 | A data byte is being read at the current pointer |
| stop_pulse | input | 1 | End of a valid transfer |
| bat_mode | input | 1 | Device runs from the backup supply |
| pwr_up | input | 1 | Power returned after total loss |
| status_o | output | 8 | Status byte |
| wr_allow | output | 1 | The current write byte may update its target |
| ack_suppress | output | 1 | Do not acknowledge the current write byte |
| next_addr | output | 6 | Pointer for the next data byte |
| commit_o | output | 1 | Staged updates of the finished transfer may be applied |

## Verification
wr_allow and ack_suppress are combinational on the strobe, so they are due in the same cycle the byte is driven. next_addr, status_o and the clock-fail flag are registered and due one cycle after the strobe or pulse. commit_o is due one cycle after stop_pulse. The BAT bit is due one cycle after bat_mode changes. The driver stamps every expected item with its due cycle: the current one for gating results and the next one for registered results. The monitor compares items only in that cycle, at a point late in the low clock phase when every input has settled.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 8;
  localparam int SEC_LEN = 8;
  localparam int SEC_LB  = $clog2(SEC_LEN);

  localparam logic [ADDR_W-1:0] ALM0_BASE = 6'h00;
  localparam logic [ADDR_W-1:0] ALM1_BASE = 6'h08;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 6'h10;
  localparam logic [ADDR_W-1:0] CLK_BASE  = 6'h30;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 6'h3F;

  localparam logic [DATA_W-1:0] CODE_LOCK = 8'h00;
  localparam logic [DATA_W-1:0] CODE_WEL  = 8'h02;
  localparam logic [DATA_W-1:0] CODE_BOTH = 8'h06;

  typedef enum logic [2:0] {
    SEC_ALM0, SEC_ALM1, SEC_CTRL, SEC_CLK, SEC_STAT, SEC_ARR, SEC_NONE
  } sec_e;

  function automatic sec_e sec_of(logic [ADDR_W-1:0] a);
    sec_e s;
    if (a == STAT_ADDR)                                      s = SEC_STAT;
    else if (a == CTRL_ADDR)                                 s = SEC_CTRL;
    else if (a[ADDR_W-1:SEC_LB] == ALM0_BASE[ADDR_W-1:SEC_LB]) s = SEC_ALM0;
    else if (a[ADDR_W-1:SEC_LB] == ALM1_BASE[ADDR_W-1:SEC_LB]) s = SEC_ALM1;
    else if (a[ADDR_W-1:SEC_LB] == CLK_BASE[ADDR_W-1:SEC_LB])  s = SEC_CLK;
    else                                                     s = SEC_NONE;
    return s;
  endfunction
endpackage

// File: rtl/wsc_addr_ptr.sv
module wsc_addr_ptr
  import wsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              load_arr,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr,
  output sec_e              sec
);
  logic [ADDR_W-1:0] ptr_q, ptr_d, step_a;
  logic              arr_q, arr_d;

  assign sec = arr_q ? SEC_ARR : sec_of(ptr_q);
  assign ptr = ptr_q;

  always_comb begin
    case (sec)
      SEC_ALM0, SEC_ALM1, SEC_CLK:
        step_a = {ptr_q[ADDR_W-1:SEC_LB], ptr_q[SEC_LB-1:0] + 1'b1};
      SEC_CTRL, SEC_STAT:
        step_a = ptr_q;
      default:
        step_a = ptr_q + 1'b1;
    endcase
    ptr_d = ptr_q;
    arr_d = arr_q;
    if (load) begin
      ptr_d = load_addr;
      arr_d = load_arr;
    end else if (adv) begin
      ptr_d = step_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      arr_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      arr_q <= arr_d;
    end
  end

  // R10
  sec_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && (sec == SEC_ALM0 || sec == SEC_ALM1 || sec == SEC_CLK))
    |=> ptr_q[ADDR_W-1:SEC_LB] == $past(ptr_q[ADDR_W-1:SEC_LB]));

  // R10
  single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && (sec == SEC_CTRL || sec == SEC_STAT)) |=> $stable(ptr_q));
endmodule

// File: rtl/wsc_unlock.sv
module wsc_unlock
  import wsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pwr_up,
  output logic              wel,
  output logic              rwel
);
  logic wel_q, wel_d, rwel_q, rwel_d;

  always_comb begin
    wel_d  = wel_q;
    rwel_d = rwel_q;
    if (pwr_up) begin
      wel_d  = 1'b0;
      rwel_d = 1'b0;
    end else if (stat_wr) begin
      case (wr_data)
        CODE_LOCK: begin wel_d = 1'b0; rwel_d = 1'b0; end
        CODE_WEL:  begin wel_d = 1'b1; rwel_d = 1'b0; end
        CODE_BOTH: if (wel_q) begin wel_d = 1'b1; rwel_d = 1'b1; end
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
    end else begin
      wel_q  <= wel_d;
      rwel_q <= rwel_d;
    end
  end

  assign wel  = wel_q;
  assign rwel = rwel_q;

  // R4
  rwel_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rwel_q |-> wel_q);

  // R4
  rwel_two_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rwel_q) |-> $past(wel_q));

  // R13
  pwr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_up |=> !wel_q && !rwel_q);
endmodule

// File: rtl/wsc_txn_gate.sv
module wsc_txn_gate
  import wsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sec_e sec,
  input  logic acc_start,
  input  logic wr_stb,
  input  logic rd_stb,
  input  logic stop_pulse,
  input  logic wel,
  input  logic rwel,
  output logic wr_allow,
  output logic ack_suppress,
  output logic stat_wr,
  output logic adv,
  output logic rtcf_clr,
  output logic commit_o
);
  logic wr_go, rd_go, allow_c, sup_c, commit_d;
  logic dirty_q, dirty_d, need_q, need_d, clk_q, clk_d, ended_q, ended_d, commit_q;

  assign wr_go = wr_stb & ~acc_start;
  assign rd_go = rd_stb & ~acc_start;
  assign adv   = wr_go | rd_go;

  always_comb begin
    case (sec)
      SEC_STAT:                               begin allow_c = ~ended_q;    sup_c = ended_q; end
      SEC_ALM0, SEC_ALM1, SEC_CTRL, SEC_CLK:  begin allow_c = wel & rwel;  sup_c = ~wel;    end
      SEC_ARR:                                begin allow_c = wel;         sup_c = ~wel;    end
      default:                                begin allow_c = 1'b0;        sup_c = 1'b1;    end
    endcase
  end

  assign wr_allow     = wr_go & allow_c;
  assign ack_suppress = wr_go & sup_c;
  assign stat_wr      = wr_allow & (sec == SEC_STAT);

  assign commit_d = stop_pulse & dirty_q & wel & (rwel | ~need_q);
  assign rtcf_clr = commit_d & clk_q;

  always_comb begin
    dirty_d = dirty_q;
    need_d  = need_q;
    clk_d   = clk_q;
    ended_d = ended_q;
    if (acc_start || stop_pulse) begin
      dirty_d = 1'b0;
      need_d  = 1'b0;
      clk_d   = 1'b0;
      ended_d = 1'b0;
    end else begin
      if (wr_allow && sec != SEC_STAT) begin
        dirty_d = 1'b1;
        if (sec != SEC_ARR) need_d = 1'b1;
        if (sec == SEC_CLK) clk_d  = 1'b1;
      end
      if (adv && sec == SEC_STAT) ended_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty_q  <= 1'b0;
      need_q   <= 1'b0;
      clk_q    <= 1'b0;
      ended_q  <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      dirty_q  <= dirty_d;
      need_q   <= need_d;
      clk_q    <= clk_d;
      ended_q  <= ended_d;
      commit_q <= commit_d;
    end
  end

  assign commit_o = commit_q;

  // R12
  commit_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> $past(stop_pulse) && $past(wel));

  // R6
  stat_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !stop_pulse) |=> !stat_wr);
endmodule

// File: rtl/wsc_status.sv
module wsc_status
  import wsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bat_mode,
  input  logic              pwr_up,
  input  logic              rtcf_clr,
  input  logic              wel,
  input  logic              rwel,
  output logic [DATA_W-1:0] status
);
  logic bat_q, rtcf_q, rtcf_d;

  always_comb begin
    rtcf_d = rtcf_q;
    if (pwr_up)        rtcf_d = 1'b1;
    else if (rtcf_clr) rtcf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bat_q  <= 1'b0;
      rtcf_q <= 1'b1;
    end else begin
      bat_q  <= bat_mode;
      rtcf_q <= rtcf_d;
    end
  end

  assign status = {bat_q, 4'b0000, rwel, wel, rtcf_q};

  // R13
  pwr_sets_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_up |=> rtcf_q);

  // R2
  bat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> status[DATA_W-1] == $past(bat_mode));
endmodule

// File: rtl/wel_status_ctrl.sv
module wel_status_ctrl
  import wsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_start,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_arr,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_stb,
  input  logic              stop_pulse,
  input  logic              bat_mode,
  input  logic              pwr_up,
  output logic [DATA_W-1:0] status_o,
  output logic              wr_allow,
  output logic              ack_suppress,
  output logic [ADDR_W-1:0] next_addr,
  output logic              commit_o
);
  logic [SYNC_STAGES-1:0] rst_sr;
  logic rst_s_n, wel, rwel, stat_wr, adv, rtcf_clr;
  sec_e sec;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sr <= '0;
        else        rst_sr <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sr <= '0;
        else        rst_sr <= {rst_sr[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate
  assign rst_s_n = rst_sr[SYNC_STAGES-1];

  wsc_addr_ptr u_ptr (
    .clk(clk), .rst_n(rst_s_n), .load(acc_start), .load_addr(acc_addr),
    .load_arr(acc_arr), .adv(adv), .ptr(next_addr), .sec(sec)
  );

  wsc_txn_gate u_gate (
    .clk(clk), .rst_n(rst_s_n), .sec(sec), .acc_start(acc_start),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .stop_pulse(stop_pulse),
    .wel(wel), .rwel(rwel), .wr_allow(wr_allow), .ack_suppress(ack_suppress),
    .stat_wr(stat_wr), .adv(adv), .rtcf_clr(rtcf_clr), .commit_o(commit_o)
  );

  wsc_unlock u_unlock (
    .clk(clk), .rst_n(rst_s_n), .stat_wr(stat_wr), .wr_data(wr_data),
    .pwr_up(pwr_up), .wel(wel), .rwel(rwel)
  );

  wsc_status u_stat (
    .clk(clk), .rst_n(rst_s_n), .bat_mode(bat_mode), .pwr_up(pwr_up),
    .rtcf_clr(rtcf_clr), .wel(wel), .rwel(rwel), .status(status_o)
  );

  // R13
  fail_fall_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(status_o[0]) |-> commit_o);

  // R7
  allow_not_sup_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_allow |-> !ack_suppress);
endmodule

// File: tb/wel_status_ctrl_test.sv
module wel_status_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_start = 0, acc_arr = 0, wr_stb = 0, rd_stb = 0, stop_pulse = 0;
  logic bat_mode = 0, pwr_up = 0;
  logic [5:0] acc_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] status_o;
  logic wr_allow, ack_suppress, commit_o;
  logic [5:0] next_addr;

  int cyc = 0, checks = 0, errs = 0;
  bit done = 0;

  typedef struct { int due; int sig; logic [7:0] val; string tag; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wel_status_ctrl uut (
    .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_addr(acc_addr),
    .acc_arr(acc_arr), .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
    .stop_pulse(stop_pulse), .bat_mode(bat_mode), .pwr_up(pwr_up),
    .status_o(status_o), .wr_allow(wr_allow), .ack_suppress(ack_suppress),
    .next_addr(next_addr), .commit_o(commit_o)
  );

  function automatic logic [7:0] obs(int s);
    case (s)
      0: return status_o;
      1: return {7'b0, wr_allow};
      2: return {7'b0, ack_suppress};
      3: return {2'b0, next_addr};
      default: return {7'b0, commit_o};
    endcase
  endfunction

  // sig: 0 status, 1 wr_allow, 2 ack_suppress, 3 next_addr, 4 commit
  task automatic push(int d, int s, logic [7:0] v, string t);
    exp_t e;
    e.due = cyc + d; e.sig = s; e.val = v; e.tag = t;
    q.push_back(e);
  endtask

  // monitor: compares each expected item in its due cycle
  initial forever begin
    @(negedge clk); #3;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due <= cyc) begin
        logic [7:0] got;
        got = obs(q[i].sig);
        checks++;
        if (got !== q[i].val || q[i].due != cyc) begin
          errs++;
          $display("FAIL %s sig%0d actual=%h expected=%h", q[i].tag, q[i].sig, got, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic drv(bit st, logic [5:0] a, bit arr, bit w, logic [7:0] d, bit r, bit sp, bit pu);
    @(negedge clk);
    acc_start = st; acc_addr = a; acc_arr = arr; wr_stb = w; wr_data = d;
    rd_stb = r; stop_pulse = sp; pwr_up = pu;
  endtask

  task automatic idle(); drv(0, 0, 0, 0, 0, 0, 0, 0); endtask

  task automatic start(logic [5:0] a, bit arr, string t);
    drv(1, a, arr, 0, 0, 0, 0, 0);
    push(1, 3, {2'b0, a}, t);
  endtask

  task automatic wr(logic [7:0] d, bit al, bit sp, logic [5:0] nx, string t);
    drv(0, 0, 0, 1, d, 0, 0, 0);
    push(0, 1, {7'b0, al}, t);
    push(0, 2, {7'b0, sp}, t);
    push(1, 3, {2'b0, nx}, t);
  endtask

  task automatic rd(logic [5:0] nx, string t);
    drv(0, 0, 0, 0, 0, 1, 0, 0);
    push(1, 3, {2'b0, nx}, t);
  endtask

  task automatic stop(bit cm, string t);
    drv(0, 0, 0, 0, 0, 0, 1, 0);
    push(1, 4, {7'b0, cm}, t);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    push(0, 0, 8'h01, "R1"); push(0, 3, 8'h00, "R1");
    push(0, 1, 8'h00, "R1"); push(0, 2, 8'h00, "R1"); push(0, 4, 8'h00, "R1");
    // R2 battery bit
    idle(); bat_mode = 1'b1; push(1, 0, 8'h81, "R2");
    idle(); bat_mode = 1'b0; push(1, 0, 8'h01, "R2");
    // R7 locked register write
    start(6'h00, 0, "R11"); wr(8'h55, 0, 1, 6'h01, "R7"); stop(0, "R12");
    // R4 06h without WEL
    start(6'h3F, 0, "R11"); wr(8'h06, 1, 0, 6'h3F, "R4"); push(1, 0, 8'h01, "R4"); stop(0, "R12");
    // R3 arm WEL, R6 second status byte
    start(6'h3F, 0, "R3"); wr(8'h02, 1, 0, 6'h3F, "R3"); push(1, 0, 8'h03, "R3");
    wr(8'h06, 0, 1, 6'h3F, "R6"); push(1, 0, 8'h03, "R6"); stop(0, "R6");
    // R7 WEL only
    start(6'h08, 0, "R11"); wr(8'hAA, 0, 0, 6'h09, "R7"); stop(0, "R12");
    // R5 other value
    start(6'h3F, 0, "R5"); wr(8'h04, 1, 0, 6'h3F, "R5"); push(1, 0, 8'h03, "R5"); stop(0, "R5");
    // R4 second step
    start(6'h3F, 0, "R4"); wr(8'h06, 1, 0, 6'h3F, "R4"); push(1, 0, 8'h07, "R4"); stop(0, "R4");
    // R10 alarm section wrap, R12 commit
    start(6'h05, 0, "R10");
    wr(8'h11, 1, 0, 6'h06, "R7"); wr(8'h12, 1, 0, 6'h07, "R10");
    wr(8'h13, 1, 0, 6'h00, "R10"); wr(8'h14, 1, 0, 6'h01, "R10");
    stop(1, "R12"); push(1, 0, 8'h07, "R13");
    // R13 clock write clears fail flag
    start(6'h36, 0, "R13"); wr(8'h21, 1, 0, 6'h37, "R13"); wr(8'h22, 1, 0, 6'h30, "R10");
    stop(1, "R13"); push(1, 0, 8'h06, "R13");
    // R10 control section holds
    start(6'h10, 0, "R10"); wr(8'h40, 1, 0, 6'h10, "R10"); rd(6'h10, "R10"); stop(1, "R12");
    // R8 unmapped
    start(6'h20, 0, "R8"); wr(8'h33, 0, 1, 6'h21, "R8"); stop(0, "R8");
    // R11 reads
    start(6'h0E, 0, "R11"); rd(6'h0F, "R11"); rd(6'h08, "R11"); stop(0, "R11");
    start(6'h3F, 0, "R11"); rd(6'h3F, "R11"); rd(6'h3F, "R10"); stop(0, "R11");
    // R9 array with WEL
    start(6'h3E, 1, "R9"); wr(8'h01, 1, 0, 6'h3F, "R9"); wr(8'h02, 1, 0, 6'h00, "R9"); stop(1, "R9");
    // R5 lock, then R9 array without WEL
    start(6'h3F, 0, "R5"); wr(8'h00, 1, 0, 6'h3F, "R5"); push(1, 0, 8'h00, "R5"); stop(0, "R5");
    start(6'h00, 1, "R9"); wr(8'h09, 0, 1, 6'h01, "R9"); stop(0, "R9");
    // R13 power-up event
    start(6'h3F, 0, "R3"); wr(8'h02, 1, 0, 6'h3F, "R3"); push(1, 0, 8'h02, "R3"); stop(0, "R3");
    drv(0, 0, 0, 0, 0, 0, 0, 1); push(1, 0, 8'h01, "R13");
    idle();
    repeat (4) idle();
    foreach (q[i]) begin
      checks++; errs++;
      $display("FAIL %s pending actual=none expected=%h", q[i].tag, q[i].val);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule